// File: doc/BRIEF.md
# Register-Write Command Sequencer

This block is a small execution engine that walks a range of a command memory one 32-bit word at a time, in address order and without branching. Each word is either a register write, which the engine places on a write-only register bus as a single-cycle strobe with a full 32-bit address and data, or a stall, which holds the engine for a programmed number of clocks. A third encoding is accepted and executed as a no-op.

After every register write the engine inserts an automatic idle of a programmable number of clocks, the write spacing. A plain run of writes therefore behaves like a run of write-plus-wait pairs, which keeps waveform-style programs short. Stall commands never receive this extra idle. A controller sets the first and last command addresses, raises enable to start, can freeze the engine with halt and resume it later at the same point, and can abort a run by dropping enable. The command memory is an external synchronous RAM with one cycle of read latency.

Top module: `cmd_seq_core`

## Requirements
- R1: A word with bit 31 = 1 is a register write; its bits [30:24] give register address bits [8:2], and all other bits of the 16-bit `reg_wr_addr` are zero, so targets run from 0x000 to 0x1FC on word boundaries.
- R2: A write drives `reg_wr_data` bits [23:0] from command bits [23:0] and bits [31:24] as zero, and `reg_wr_en` is high for exactly one cycle per write command.
- R3: Commands are fetched in increasing address order from `start_addr` up to and including `end_addr` (the address wraps at the memory size); a write strobe appears two clocks after the clock that places its address on `mem_addr`.
- R4: After each write command, including the last one, the engine idles for `wr_spacing` clocks before the next fetch or before finishing; a spacing of zero adds no idle.
- R5: A word with bit 31 = 0 and bit 30 = 0 is a stall for bits [29:0] clocks, a count of zero acting as one clock; no write-spacing idle follows a stall.
- R6: A word with bit 31 = 0 and bit 30 = 1 produces no write, no stall and no write-spacing idle.
- R7: When idle with `enable` high, `halt` low and `done` low, the next clock begins a run: `busy` rises and the first fetch reads `start_addr`.
- R8: When the last command and its trailing idle are complete, `busy` falls and `done` rises on the same clock; `done` stays high and no new run begins while `enable` stays high.
- R9: While `halt` is high, fetches, command execution and stall counting are frozen with no strobe; clearing it resumes at the same point with the remaining timing unchanged.
- R10: When `enable` is low at a clock edge, the engine is idle after that edge with `busy`, `done` and `reg_wr_en` low; a pending stall is discarded.
- R11: During reset `busy`, `done`, `reg_wr_en` and `mem_rd_en` are low.
- R12: `mem_rd_en` is high for exactly one cycle per command fetch, only while running with `enable` high and `halt` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run permission; low aborts and clears done |
| halt | input | 1 | Freezes the engine while high |
| start_addr | input | AW | First command address |
| end_addr | input | AW | Last command address, inclusive |
| wr_spacing | input | SPW | Idle clocks inserted after each write |
| mem_rd_en | output | 1 | Command memory read request |
| mem_addr | output | AW | Command memory read address |
| mem_rdata | input | 32 | Command word, valid one clock after the read |
| reg_wr_en | output | 1 | Register write strobe |
| reg_wr_addr | output | 16 | Register byte address |
| reg_wr_data | output | 32 | Register write data |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | High after a run completes until enable drops |

## Verification
Every result has a fixed latency counted in unhalted clocks from the start edge: the fetch of a command is due at its slot, its write strobe two unhalted clocks later, and the next slot follows after the write spacing, the stall length, or nothing. The bench derives all slots and the completion clock from the memory contents and the spacing before a run, then keeps a running count of unhalted clocks, so a halted clock shifts every later result by one. Outputs are sampled at the falling edge after each rising edge and compared against that schedule on every clock, and phase-end checks confirm write counts, busy durations and the abort and restart behaviour.

// File: rtl/cmd_seq_pkg.sv
package cmd_seq_pkg;

    localparam int CMD_W        = 32;
    localparam int REG_ADDR_W   = 16;
    localparam int REG_DATA_W   = 32;
    localparam int FLD_ADDR_W   = 7;
    localparam int FLD_DATA_W   = 24;
    localparam int WAIT_W       = 30;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_FETCH = 2'd1,
        SQ_EXEC  = 2'd2,
        SQ_STALL = 2'd3
    } seq_state_e;

    typedef enum logic [1:0] {
        CK_WRITE = 2'd0,
        CK_WAIT  = 2'd1,
        CK_SKIP  = 2'd2
    } cmd_kind_e;

endpackage

// File: rtl/cmd_seq_decode.sv
module cmd_seq_decode
    import cmd_seq_pkg::*;
(
    input  logic [CMD_W-1:0]      cmd,
    output cmd_kind_e             kind,
    output logic [REG_ADDR_W-1:0] wr_addr,
    output logic [REG_DATA_W-1:0] wr_data,
    output logic [WAIT_W-1:0]     stall_len
);

    localparam int ADDR_LSB  = 2;
    localparam int ADDR_HI_Z = REG_ADDR_W - FLD_ADDR_W - ADDR_LSB;
    localparam int DATA_HI_Z = REG_DATA_W - FLD_DATA_W;

    logic [FLD_ADDR_W-1:0] addr_field;
    logic [FLD_DATA_W-1:0] data_field;
    logic [WAIT_W-1:0]     wait_field;

    always_comb begin
        addr_field = cmd[CMD_W-2 -: FLD_ADDR_W];
        data_field = cmd[FLD_DATA_W-1:0];
        wait_field = cmd[WAIT_W-1:0];

        if (cmd[CMD_W-1]) begin
            kind = CK_WRITE;
        end else if (!cmd[CMD_W-2]) begin
            kind = CK_WAIT;
        end else begin
            kind = CK_SKIP;
        end

        wr_addr   = {{ADDR_HI_Z{1'b0}}, addr_field, {ADDR_LSB{1'b0}}};
        wr_data   = {{DATA_HI_Z{1'b0}}, data_field};
        stall_len = (wait_field == '0) ? WAIT_W'(1) : wait_field;
    end

endmodule

// File: rtl/cmd_seq_stall_timer.sv
module cmd_seq_stall_timer #(
    parameter int CNT_W = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    input  logic             clear,
    output logic             last
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_regs_t;

    tmr_regs_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (clear) begin
            tmr_d.cnt = '0;
        end else if (load) begin
            tmr_d.cnt = load_val;
        end else if (run && (tmr_q.cnt != '0)) begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign last = (tmr_q.cnt == CNT_W'(1));

    // R5: a stall or spacing is never loaded with zero length
    p_load_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val != '0));

    // R9: the count is frozen whenever the controller neither loads, runs nor clears it
    p_count_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !run && !clear) |=> $stable(tmr_q.cnt));

endmodule

// File: rtl/cmd_seq_core.sv
module cmd_seq_core
    import cmd_seq_pkg::*;
#(
    parameter int AW  = 10,
    parameter int SPW = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enable,
    input  logic                  halt,
    input  logic [AW-1:0]         start_addr,
    input  logic [AW-1:0]         end_addr,
    input  logic [SPW-1:0]        wr_spacing,
    output logic                  mem_rd_en,
    output logic [AW-1:0]         mem_addr,
    input  logic [CMD_W-1:0]      mem_rdata,
    output logic                  reg_wr_en,
    output logic [REG_ADDR_W-1:0] reg_wr_addr,
    output logic [REG_DATA_W-1:0] reg_wr_data,
    output logic                  busy,
    output logic                  done
);

    localparam int CNT_W = WAIT_W;

    typedef struct packed {
        seq_state_e            st;
        logic [AW-1:0]         pc;
        logic                  done;
        logic                  wr_en;
        logic [REG_ADDR_W-1:0] wr_addr;
        logic [REG_DATA_W-1:0] wr_data;
    } seq_regs_t;

    localparam seq_regs_t SEQ_RST = '{
        st:      SQ_IDLE,
        pc:      '0,
        done:    1'b0,
        wr_en:   1'b0,
        wr_addr: '0,
        wr_data: '0
    };

    seq_regs_t seq_d, seq_q;

    cmd_kind_e             dec_kind;
    logic [REG_ADDR_W-1:0] dec_addr;
    logic [REG_DATA_W-1:0] dec_data;
    logic [WAIT_W-1:0]     dec_stall;

    logic             t_load;
    logic [CNT_W-1:0] t_val;
    logic             t_run;
    logic             t_clear;
    logic             t_last;
    logic             step;

    cmd_seq_decode u_decode (
        .cmd       (mem_rdata),
        .kind      (dec_kind),
        .wr_addr   (dec_addr),
        .wr_data   (dec_data),
        .stall_len (dec_stall)
    );

    cmd_seq_stall_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .run      (t_run),
        .clear    (t_clear),
        .last     (t_last)
    );

    always_comb begin
        seq_d       = seq_q;
        seq_d.wr_en = 1'b0;
        t_load      = 1'b0;
        t_val       = '0;
        t_run       = 1'b0;
        t_clear     = 1'b0;
        step        = 1'b0;

        if (!enable) begin
            seq_d.st   = SQ_IDLE;
            seq_d.done = 1'b0;
            t_clear    = 1'b1;
        end else if (!halt) begin
            unique case (seq_q.st)
                SQ_IDLE: begin
                    if (!seq_q.done) begin
                        seq_d.st = SQ_FETCH;
                        seq_d.pc = start_addr;
                    end
                end
                SQ_FETCH: begin
                    seq_d.st = SQ_EXEC;
                end
                SQ_EXEC: begin
                    unique case (dec_kind)
                        CK_WRITE: begin
                            seq_d.wr_en   = 1'b1;
                            seq_d.wr_addr = dec_addr;
                            seq_d.wr_data = dec_data;
                            if (wr_spacing != '0) begin
                                t_load   = 1'b1;
                                t_val    = CNT_W'(wr_spacing);
                                seq_d.st = SQ_STALL;
                            end else begin
                                step = 1'b1;
                            end
                        end
                        CK_WAIT: begin
                            t_load   = 1'b1;
                            t_val    = dec_stall;
                            seq_d.st = SQ_STALL;
                        end
                        default: begin
                            step = 1'b1;
                        end
                    endcase
                end
                SQ_STALL: begin
                    t_run = 1'b1;
                    if (t_last) begin
                        step = 1'b1;
                    end
                end
                default: begin
                    seq_d.st = SQ_IDLE;
                end
            endcase

            if (step) begin
                if (seq_q.pc == end_addr) begin
                    seq_d.st   = SQ_IDLE;
                    seq_d.done = 1'b1;
                end else begin
                    seq_d.st = SQ_FETCH;
                    seq_d.pc = seq_q.pc + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= SEQ_RST;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign mem_rd_en   = (seq_q.st == SQ_FETCH) && enable && !halt;
    assign mem_addr    = seq_q.pc;
    assign reg_wr_en   = seq_q.wr_en;
    assign reg_wr_addr = seq_q.wr_addr;
    assign reg_wr_data = seq_q.wr_data;
    assign busy        = (seq_q.st != SQ_IDLE);
    assign done        = seq_q.done;

    // R2: a write strobe never lasts more than one cycle
    p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en);

    // R7: an idle, permitted engine starts and points at the start address
    p_start_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done && enable && !halt) |=> (busy && (mem_addr == $past(start_addr))));

    // R8: done and busy are never high together
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9: a halted run keeps its position and issues no write
    p_halt_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && enable && halt) |=> (busy && $stable(mem_addr) && !reg_wr_en));

    // R10: dropping enable empties the engine on the next clock
    p_enable_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!busy && !done && !reg_wr_en));

    // R12: each fetch is a single read followed by execution
    p_fetch_once_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

endmodule

// File: tb/cmd_seq_core_tb.sv
module cmd_seq_core_tb;

    localparam int AW  = 10;
    localparam int SPW = 8;
    localparam int MAXN = 32;

    logic          clk;
    logic          rst_n;
    logic          drv_en;
    logic          drv_halt;
    logic [AW-1:0] start_addr;
    logic [AW-1:0] end_addr;
    logic [SPW-1:0] wr_spacing;
    logic          mem_rd_en;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_rdata;
    logic          reg_wr_en;
    logic [15:0]   reg_wr_addr;
    logic [31:0]   reg_wr_data;
    logic          busy;
    logic          done;

    logic [31:0] ram [0:(1<<AW)-1];

    int chk_n = 0;
    int fail_n = 0;

    // reference schedule, in unhalted clocks since the start edge
    int          n_wr;
    int          wr_t  [0:MAXN-1];
    logic [15:0] wr_ad [0:MAXN-1];
    logic [31:0] wr_dt [0:MAXN-1];
    int          n_f;
    int          f_t   [0:MAXN-1];
    logic [AW-1:0] f_ad [0:MAXN-1];
    int          end_a;

    bit m_run = 0;
    bit m_done = 0;
    int m_a = 0;
    int wr_seen = 0;
    int busy_n = 0;
    int halted_n = 0;

    cmd_seq_core #(
        .AW  (AW),
        .SPW (SPW)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (drv_en),
        .halt        (drv_halt),
        .start_addr  (start_addr),
        .end_addr    (end_addr),
        .wr_spacing  (wr_spacing),
        .mem_rd_en   (mem_rd_en),
        .mem_addr    (mem_addr),
        .mem_rdata   (mem_rdata),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_addr (reg_wr_addr),
        .reg_wr_data (reg_wr_data),
        .busy        (busy),
        .done        (done)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    always_ff @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= ram[mem_addr];
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        chk_n++;
        if (!ok) begin
            fail_n++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic build_sched();
        logic [AW-1:0] pc;
        logic [31:0] c;
        int f;
        int dly;
        pc = start_addr;
        f = 0;
        n_wr = 0;
        n_f = 0;
        forever begin
            c = ram[pc];
            f_t[n_f] = f;
            f_ad[n_f] = pc;
            n_f++;
            if (c[31]) begin
                wr_t[n_wr]  = f + 2;
                wr_ad[n_wr] = {7'd0, c[30:24], 2'b00};
                wr_dt[n_wr] = {8'd0, c[23:0]};
                n_wr++;
                dly = int'(wr_spacing);
            end else if (!c[30]) begin
                dly = (c[29:0] == 30'd0) ? 1 : int'(c[29:0]);
            end else begin
                dly = 0;
            end
            f = f + 2 + dly;
            if (pc == end_addr) break;
            pc = pc + 1'b1;
        end
        end_a = f;
    endtask

    task automatic step();
        bit adv;
        bit exp_wr;
        bit exp_rd;
        logic [15:0] ea;
        logic [31:0] ed;
        logic [AW-1:0] era;
        @(negedge clk);
        if (m_run && drv_en && drv_halt && rst_n) halted_n++;
        adv = 0;
        if (!rst_n || !drv_en) begin
            m_run = 0;
            m_done = 0;
        end else if (!drv_halt) begin
            if (m_run) begin
                m_a++;
                adv = 1;
                if (m_a == end_a) begin
                    m_run = 0;
                    m_done = 1;
                end
            end else if (!m_done) begin
                m_run = 1;
                m_a = 0;
            end
        end
        exp_wr = 0; ea = '0; ed = '0;
        for (int i = 0; i < n_wr; i++) begin
            if (adv && wr_t[i] == m_a) begin exp_wr = 1; ea = wr_ad[i]; ed = wr_dt[i]; end
        end
        exp_rd = 0; era = '0;
        for (int j = 0; j < n_f; j++) begin
            if (m_run && drv_en && !drv_halt && f_t[j] == m_a) begin exp_rd = 1; era = f_ad[j]; end
        end
        check(reg_wr_en == exp_wr, "R3", "write strobe timing", 32'(reg_wr_en), 32'(exp_wr));
        if (exp_wr && reg_wr_en) begin
            check(reg_wr_addr == ea, "R1", "write address", 32'(reg_wr_addr), 32'(ea));
            check(reg_wr_data == ed, "R2", "write data", reg_wr_data, ed);
        end
        check(mem_rd_en == exp_rd, "R12", "fetch request", 32'(mem_rd_en), 32'(exp_rd));
        if (exp_rd && mem_rd_en)
            check(mem_addr == era, "R3", "fetch address order", 32'(mem_addr), 32'(era));
        check(busy == m_run, "R7", "busy", 32'(busy), 32'(m_run));
        check(done == m_done, "R8", "done", 32'(done), 32'(m_done));
        if (busy) busy_n++;
        if (reg_wr_en) wr_seen++;
    endtask

    task automatic run_to_done();
        int g;
        g = 0;
        while (!m_done && g < 5000) begin
            step();
            g++;
        end
    endtask

    task automatic go_idle();
        drv_en = 1'b0;
        drv_halt = 1'b0;
        step();
        step();
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", chk_n - fail_n, chk_n);
    endtask

    initial begin
        #400000;
        chk_n++;
        fail_n++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < (1 << AW); i++) ram[i] = 32'h4000_0000;
        // program A at 0..4
        ram[0]  = 32'h80FF_FFFF;
        ram[1]  = 32'hFF12_3456;
        ram[2]  = 32'h85A5_A5A5;
        ram[3]  = 32'h0000_0005;
        ram[4]  = 32'hC000_0001;
        // program B at 10..14
        ram[10] = 32'h8A00_0042;
        ram[11] = 32'h0000_0000;
        ram[12] = 32'h4000_1234;
        ram[13] = 32'h9F0F_0F0F;
        ram[14] = 32'h0000_0002;
        // program C at 20..22
        ram[20] = 32'h8100_0001;
        ram[21] = 32'h0000_0028;
        ram[22] = 32'h8200_0002;

        mem_rdata  = '0;
        rst_n      = 1'b0;
        drv_en     = 1'b0;
        drv_halt   = 1'b0;
        start_addr = '0;
        end_addr   = 10'd4;
        wr_spacing = '0;
        n_wr = 0;
        n_f = 0;
        end_a = 0;

        // R11: reset state
        step();
        step();
        check(!busy && !done && !reg_wr_en && !mem_rd_en, "R11", "outputs in reset",
              {28'd0, busy, done, reg_wr_en, mem_rd_en}, 32'd0);
        rst_n = 1'b1;
        step();

        // Phase A: back-to-back writes, zero spacing, addresses at both ends of range
        build_sched();
        wr_seen = 0;
        drv_en = 1'b1;
        run_to_done();
        check(wr_seen == 4, "R3", "writes in program A", 32'(wr_seen), 32'd4);
        for (int k = 0; k < 5; k++) step();
        check(done && !busy && wr_seen == 4, "R8", "done held, no rerun",
              {30'd0, done, busy}, 32'd2);
        drv_en = 1'b0;
        step();
        check(!done && !busy, "R10", "enable low clears done", {30'd0, done, busy}, 32'd0);
        step();

        // Phase B: spacing, zero stall, reserved word
        start_addr = 10'd10;
        end_addr   = 10'd14;
        wr_spacing = 8'd3;
        build_sched();
        wr_seen = 0;
        busy_n = 0;
        drv_en = 1'b1;
        run_to_done();
        check(wr_seen == 2, "R6", "reserved word writes nothing", 32'(wr_seen), 32'd2);
        check(busy_n == 19, "R4 R5", "busy clocks of program B", 32'(busy_n), 32'd19);
        go_idle();

        // Phase C: halt pulses during program A with spacing 2
        start_addr = 10'd0;
        end_addr   = 10'd4;
        wr_spacing = 8'd2;
        build_sched();
        wr_seen = 0;
        busy_n = 0;
        halted_n = 0;
        drv_en = 1'b1;
        step();
        for (int i = 0; i < 200 && !m_done; i++) begin
            drv_halt = (i >= 3 && i <= 5) || (i == 9) || (i >= 14 && i <= 20);
            step();
        end
        drv_halt = 1'b0;
        run_to_done();
        check(wr_seen == 4 && done, "R9", "writes after halts", 32'(wr_seen), 32'd4);
        check(busy_n == end_a + halted_n, "R9", "busy clocks with halts",
              32'(busy_n), 32'(end_a + halted_n));
        check(end_a == 23, "R4", "schedule length with spacing", 32'(end_a), 32'd23);
        go_idle();

        // Phase D: abort inside a long stall, then restart
        start_addr = 10'd20;
        end_addr   = 10'd22;
        wr_spacing = 8'd0;
        build_sched();
        wr_seen = 0;
        drv_en = 1'b1;
        for (int k = 0; k < 12; k++) step();
        check(busy == 1'b1, "R5", "still stalling", 32'(busy), 32'd1);
        drv_en = 1'b0;
        step();
        check(!busy && !done, "R10", "abort mid stall", {30'd0, busy, done}, 32'd0);
        for (int k = 0; k < 5; k++) step();
        check(wr_seen == 1, "R10", "no writes after abort", 32'(wr_seen), 32'd1);
        drv_en = 1'b1;
        step();
        check(mem_rd_en && mem_addr == 10'd20, "R7", "restart fetches start address",
              32'(mem_addr), 32'd20);
        run_to_done();
        check(wr_seen == 3, "R7", "restart runs full program", 32'(wr_seen), 32'd3);
        go_idle();

        summary();
        $finish;
    end

endmodule